// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast-Path Steering

This controller gathers 32 level-sensitive interrupt requests and routes each enabled one to one of two processor-facing lines. One line is the normal-priority line. The other is the fast-priority line. A per-source steering register picks the line for each source. Software reads three views of the sources:

- the normal view: enabled, asserted requests steered to the normal line;
- the fast view: enabled, asserted requests steered to the fast line;
- the raw view: the request inputs with no mask applied.

A bank of 32 handler-address registers holds one address for each vectored normal-priority slot. A current-vector register returns the address that belongs to the lowest-numbered active normal request. The handler can jump to that address directly.

Software reaches the block through a plain synchronous register bus: address, write enable, write data and read data. This is a control path, not a data stream, so there is no valid/ready handshake and no back-pressure. A write takes effect at the clock edge on which the write enable is high. Read data is a combinational function of the address and the current state. The enable state has one offset that only sets bits and a second offset that only clears bits. Software can therefore change some sources without a read-modify-write sequence.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset, the steering, enable and handler-address registers are all 0. Both outputs are low, and every status view of a masked source reads 0.
- R2: Writing to offset 0x010 sets every enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. Writing to offset 0x014 clears every enable bit whose write-data bit is 1. Reading offset 0x010 returns the enable state, with bit n belonging to source n.
- R3: Offset 0x00C is the read/write steering register. In bit n, a 0 routes source n to the normal line and a 1 routes it to the fast line.
- R4: Reading offset 0x000 returns the normal status. Bit n is 1 exactly when request n is high, enable n is 1 and steering bit n is 0.
- R5: Reading offset 0x004 returns the fast status. Bit n is 1 exactly when request n is high, enable n is 1 and steering bit n is 1.
- R6: Reading offset 0x008 returns the request inputs unmasked, whatever the enable and steering settings.
- R7: `irq_o` is the OR of the normal status bits and `fiq_o` is the OR of the fast status bits. Both are registered, so each follows a change one clock edge later.
- R8: Slot n's handler address is a read/write 32-bit register at offset 0x100 + 4*n, for n = 0..31.
- R9: Reading offset 0x030 returns the handler address of the lowest-numbered set bit of the normal status. It returns 0 when the normal status is 0.
- R10: Writes to the read-only offsets 0x000, 0x004, 0x008 and 0x030 change no state.
- R11: Reads return 0 from an offset that is not mapped, from an address in the handler region that is not word-aligned, and from the clear-only offset 0x014.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous |
| bus_addr_i | input | 12 | Register byte offset |
| bus_we_i | input | 1 | Write strobe for the current cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| req_i | input | 32 | Level-sensitive interrupt requests, bit n = source n |
| irq_o | output | 1 | Normal-priority interrupt line |
| fiq_o | output | 1 | Fast-priority interrupt line |

## Verification
The bench walks every source through both steering settings, enabled and then disabled. If the masking is wrong, a request leaks into the wrong status view or onto the wrong line. It also checks that each line stays at its old value just before the edge, so a design with an unregistered line is caught.

Several normal requests are raised together with mixed steering to test the priority choice. A scan that picks the highest-numbered bit, or that counts fast-steered requests, returns the wrong handler address.

Enable updates are checked with overlapping set and clear masks. A design that overwrites the enable state instead of merging into it fails these checks. The bench also writes all-ones to every read-only offset and to a misaligned handler address. A decoder that does not fully qualify the address then corrupts the steering or enable state, or a handler address.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned OFF_NRM_STAT = 'h000;
  localparam int unsigned OFF_FST_STAT = 'h004;
  localparam int unsigned OFF_RAW_STAT = 'h008;
  localparam int unsigned OFF_STEER    = 'h00C;
  localparam int unsigned OFF_EN_SET   = 'h010;
  localparam int unsigned OFF_EN_CLR   = 'h014;
  localparam int unsigned OFF_CUR_VEC  = 'h030;
  localparam int unsigned OFF_VEC_BASE = 'h100;
endpackage

// File: rtl/isc_ctrl_regs.sv
module isc_ctrl_regs #(
  parameter int N_SRC = 32,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] steer_o
);
  import isc_pkg::*;

  logic [N_SRC-1:0] wbits;
  logic             hit_set, hit_clr, hit_steer;

  assign wbits     = wdata_i[N_SRC-1:0];
  assign hit_set   = we_i && (addr_i == AW'(OFF_EN_SET));
  assign hit_clr   = we_i && (addr_i == AW'(OFF_EN_CLR));
  assign hit_steer = we_i && (addr_i == AW'(OFF_STEER));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_o    <= '0;
      steer_o <= '0;
    end else begin
      if (hit_set)        en_o <= en_o | wbits;
      else if (hit_clr)   en_o <= en_o & ~wbits;
      if (hit_steer)      steer_o <= wbits;
    end
  end
endmodule

// File: rtl/isc_vec_bank.sv
module isc_vec_bank #(
  parameter int N_SRC = 32,
  parameter int AW    = 12,
  parameter int DW    = 32,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          bus_hit_o,
  output logic [DW-1:0] bus_data_o,
  input  logic [IW-1:0] pick_idx_i,
  output logic [DW-1:0] pick_data_o
);
  import isc_pkg::*;

  localparam logic [AW-1:0] BASE = AW'(OFF_VEC_BASE);
  localparam logic [AW-1:0] SPAN = AW'(N_SRC * 4);

  logic [AW-1:0] off;
  logic [IW-1:0] bus_idx;
  logic [DW-1:0] slot_q [N_SRC];

  assign off       = addr_i - BASE;
  assign bus_hit_o = (addr_i >= BASE) && (off < SPAN) && (off[1:0] == 2'b00);
  assign bus_idx   = off[IW+1:2];

  for (genvar s = 0; s < N_SRC; s++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (!rst_ni)                                      slot_q[s] <= '0;
      else if (we_i && bus_hit_o && bus_idx == IW'(s))  slot_q[s] <= wdata_i;
    end
  end

  assign bus_data_o  = slot_q[bus_idx];
  assign pick_data_o = slot_q[pick_idx_i];
endmodule

// File: rtl/isc_first_pick.sv
module isc_first_pick #(
  parameter int N_SRC = 32,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] act_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int b = N_SRC - 1; b >= 0; b--) begin
      if (act_i[b]) idx_o = IW'(b);
    end
  end
  assign any_o = |act_i;
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl #(
  parameter int N_SRC = 32,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic             bus_we_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic [N_SRC-1:0] req_i,
  output logic             irq_o,
  output logic             fiq_o
);
  import isc_pkg::*;

  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] en_q, steer_q, nrm_stat, fst_stat;
  logic             vec_hit, nrm_any;
  logic [DW-1:0]    vec_rd, pick_vec, cur_vec;
  logic [IW-1:0]    nrm_idx;
  logic             irq_q, fiq_q;

  isc_ctrl_regs #(.N_SRC(N_SRC), .AW(AW), .DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .en_o(en_q), .steer_o(steer_q)
  );

  assign nrm_stat = req_i & en_q & ~steer_q;
  assign fst_stat = req_i & en_q & steer_q;

  isc_first_pick #(.N_SRC(N_SRC)) u_pick (
    .act_i(nrm_stat), .any_o(nrm_any), .idx_o(nrm_idx)
  );

  isc_vec_bank #(.N_SRC(N_SRC), .AW(AW), .DW(DW)) u_vec (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .bus_hit_o(vec_hit), .bus_data_o(vec_rd),
    .pick_idx_i(nrm_idx), .pick_data_o(pick_vec)
  );

  assign cur_vec = nrm_any ? pick_vec : '0;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |nrm_stat;
      fiq_q <= |fst_stat;
    end
  end
  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  always_comb begin
    bus_rdata_o = '0;
    if (vec_hit) bus_rdata_o = vec_rd;
    else if (bus_addr_i == AW'(OFF_NRM_STAT)) bus_rdata_o = DW'(nrm_stat);
    else if (bus_addr_i == AW'(OFF_FST_STAT)) bus_rdata_o = DW'(fst_stat);
    else if (bus_addr_i == AW'(OFF_RAW_STAT)) bus_rdata_o = DW'(req_i);
    else if (bus_addr_i == AW'(OFF_STEER))    bus_rdata_o = DW'(steer_q);
    else if (bus_addr_i == AW'(OFF_EN_SET))   bus_rdata_o = DW'(en_q);
    else if (bus_addr_i == AW'(OFF_CUR_VEC))  bus_rdata_o = cur_vec;
  end
endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int N_SRC = 32,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    bus_addr_i,
  input logic             bus_we_i,
  input logic [DW-1:0]    bus_wdata_i,
  input logic [N_SRC-1:0] req_i,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [N_SRC-1:0] en_q,
  input logic [N_SRC-1:0] steer_q,
  input logic [DW-1:0]    cur_vec
);
  import isc_pkg::*;

  // R7: normal line is one edge behind the masked, normal-steered requests
  a_r7_irq_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(req_i & en_q & ~steer_q)));

  // R7: fast line is one edge behind the masked, fast-steered requests
  a_r7_fiq_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == $past(|(req_i & en_q & steer_q)));

  // R2: a set write leaves every written 1 bit enabled
  a_r2_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == AW'(OFF_EN_SET)) |=>
      ((en_q & $past(bus_wdata_i[N_SRC-1:0])) == $past(bus_wdata_i[N_SRC-1:0])));

  // R2: a clear write leaves every written 1 bit disabled
  a_r2_clr_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == AW'(OFF_EN_CLR)) |=>
      ((en_q & $past(bus_wdata_i[N_SRC-1:0])) == '0));

  // R3: a steering write is stored as written
  a_r3_steer_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == AW'(OFF_STEER)) |=>
      (steer_q == $past(bus_wdata_i[N_SRC-1:0])));

  // R10: a write to a read-only offset leaves enable and steering untouched
  a_r10_ro_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && (bus_addr_i == AW'(OFF_NRM_STAT) || bus_addr_i == AW'(OFF_FST_STAT) ||
                  bus_addr_i == AW'(OFF_RAW_STAT) || bus_addr_i == AW'(OFF_CUR_VEC))) |=>
      ($stable(en_q) && $stable(steer_q)));

  // R9: no active normal request means the current vector is zero
  a_r9_idle_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i & en_q & ~steer_q) == '0) |-> (cur_vec == '0));
endmodule

bind irq_steer_ctrl isc_checker #(.N_SRC(N_SRC), .AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
  .bus_wdata_i(bus_wdata_i), .req_i(req_i), .irq_o(irq_o), .fiq_o(fiq_o),
  .en_q(en_q), .steer_q(steer_q), .cur_vec(cur_vec)
);

// File: tb/irq_steer_ctrl_tb.sv
module irq_steer_ctrl_tb;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] req = '0;
  logic        irq, fiq;

  int n_run = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_steer_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .req_i(req),
    .irq_o(irq), .fiq_o(fiq)
  );

  function automatic logic [31:0] vval(int i);
    return 32'h8000_0000 ^ (32'(i) * 32'h0101_0041);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rdchk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    #1_000_000;
    n_run++; n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] en_m, st_m, rq, e_nrm, e_fst, e_vec;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq_o", {31'b0, irq}, 0);
    chk("R1 fiq_o", {31'b0, fiq}, 0);
    rdchk("R1 steer", 12'h00C, 0);
    rdchk("R1 enable", 12'h010, 0);
    rdchk("R1 normal status", 12'h000, 0);
    rdchk("R1 fast status", 12'h004, 0);
    for (int i = 0; i < N; i++) rdchk("R1 vector reset", 12'(12'h100 + 4 * i), 0);

    // R8: handler address slots
    for (int i = 0; i < N; i++) wr(12'(12'h100 + 4 * i), vval(i));
    for (int i = 0; i < N; i++) rdchk("R8 vector readback", 12'(12'h100 + 4 * i), vval(i));

    // R2: set/clear merge
    wr(12'h010, 32'hF0F0_00FF); rdchk("R2 set first", 12'h010, 32'hF0F0_00FF);
    wr(12'h010, 32'h0000_0F00); rdchk("R2 set merges", 12'h010, 32'hF0F0_0FFF);
    wr(12'h014, 32'h1000_00F0); rdchk("R2 clear", 12'h010, 32'hE0F0_0F0F);
    rdchk("R11 clear offset reads 0", 12'h014, 0);

    // R3: steering read/write
    wr(12'h00C, 32'h5A5A_C3C3); rdchk("R3 steer rw", 12'h00C, 32'h5A5A_C3C3);

    // R10: read-only offsets ignore writes
    wr(12'h000, 32'hFFFF_FFFF); wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h008, 32'hFFFF_FFFF); wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h102, 32'hFFFF_FFFF);
    rdchk("R10 steer kept", 12'h00C, 32'h5A5A_C3C3);
    rdchk("R10 enable kept", 12'h010, 32'hE0F0_0F0F);
    rdchk("R10 vector0 kept", 12'h100, vval(0));

    // R11: unmapped reads
    rdchk("R11 unmapped 0x020", 12'h020, 0);
    rdchk("R11 past vectors", 12'h180, 0);
    rdchk("R11 misaligned vector", 12'h102, 0);
    rdchk("R11 high", 12'hFFC, 0);

    // Per-source sweep: both steering values, enabled then disabled
    wr(12'h010, 32'hFFFF_FFFF);
    for (int i = 0; i < N; i++) begin
      for (int s = 0; s < 2; s++) begin
        wr(12'h00C, s ? (32'h1 << i) : 32'h0);
        @(negedge clk); req = '0;
        @(negedge clk); req = N'(1) << i;
        #1;
        chk("R7 irq_o waits an edge", {31'b0, irq}, 0);
        chk("R7 fiq_o waits an edge", {31'b0, fiq}, 0);
        rdchk("R4 normal one-hot", 12'h000, s ? 0 : (32'h1 << i));
        rdchk("R5 fast one-hot", 12'h004, s ? (32'h1 << i) : 0);
        rdchk("R6 raw", 12'h008, 32'h1 << i);
        rdchk("R9 current vector", 12'h030, s ? 0 : vval(i));
        chk("R7 irq_o", {31'b0, irq}, s ? 0 : 1);
        chk("R7 fiq_o", {31'b0, fiq}, s ? 1 : 0);
        wr(12'h014, 32'h1 << i);
        rdchk("R4 disabled normal", 12'h000, 0);
        rdchk("R5 disabled fast", 12'h004, 0);
        rdchk("R6 raw while disabled", 12'h008, 32'h1 << i);
        @(negedge clk);
        chk("R7 irq_o disabled", {31'b0, irq}, 0);
        chk("R7 fiq_o disabled", {31'b0, fiq}, 0);
        wr(12'h010, 32'h1 << i);
      end
    end

    // Mixed patterns: priority and masking together
    en_m = 32'hDEAD_BEEF; st_m = 32'h0F0F_3355; rq = 32'h1234_5678;
    for (int k = 0; k < 40; k++) begin
      wr(12'h014, 32'hFFFF_FFFF); wr(12'h010, en_m); wr(12'h00C, st_m);
      @(negedge clk); req = rq;
      e_nrm = rq & en_m & ~st_m;
      e_fst = rq & en_m & st_m;
      e_vec = 0;
      for (int b = N - 1; b >= 0; b--) if (e_nrm[b]) e_vec = vval(b);
      rdchk("R4 mixed normal", 12'h000, e_nrm);
      rdchk("R5 mixed fast", 12'h004, e_fst);
      rdchk("R9 mixed lowest", 12'h030, e_vec);
      chk("R7 mixed irq_o", {31'b0, irq}, {31'b0, |e_nrm});
      chk("R7 mixed fiq_o", {31'b0, fiq}, {31'b0, |e_fst});
      en_m = {en_m[30:0], en_m[31] ^ en_m[21] ^ en_m[1] ^ en_m[0]};
      st_m = st_m * 32'd1103515245 + 32'd12345;
      rq   = (rq ^ (rq << 7)) ^ (32'h1 << (k % 32));
      rq   = rq & (k[0] ? 32'hFFF0_0000 : 32'hFFFF_FFFF);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule